// File: doc/BRIEF.md
# Boundary Scan Pin Cell Chain

This block is the boundary register for a group of bidirectional pins. A TAP controller outside the block drives the capture, shift and update strobes and a two-bit test mode. Each pin owns a group of three cells. The lowest cell controls the output enable, the next cell holds output data, and the highest cell only observes the pad. Between pin groups, optional placeholder cells lengthen the chain. These cells capture a fixed bit and drive nothing.

On the pad side, the block chooses between the core's data and enable and the values held in its update latches. A high-impedance mode turns every driver off. For each pin, a flag shows that an open-drain pin has its driver off, so the pad sits at a weak high level rather than floating. Serial data enters at the top of the chain and leaves from cell 0, which is the control cell of pin 0.

Top module: `bscan_pin_chain`

## Requirements
- R1: While trst_n is low, and at the first rising tck edge after it is released, every shift cell and every update latch holds 0. As a result tdo is 0, and in modes 01 and 10 pad_oe and pad_out are all 0.
- R2: The chain holds NUM_PINS*(3+FILL_CELLS) cells. Pin k starts at base index k*(3+FILL_CELLS). On a rising tck edge with capture_dr high, the cell at base loads core_oe[k], base+1 loads core_do[k], base+2 loads pad_in[k], and each placeholder cell at base+3 and above loads FILL_VALUE.
- R3: When capture_dr and shift_dr are high on the same edge, the capture is performed and the shift is not.
- R4: On each rising tck edge with only shift_dr high, every cell takes the value of the cell one index above it and the top cell takes tdi. tdo always shows cell 0, so the first bit shifted in reaches tdo after a full chain length of shifts.
- R5: Only a falling tck edge with update_dr high loads the data and control cells into their update latches. Updating leaves the shift cells unchanged, and shifting leaves the latches and the test-driven pads unchanged.
- R6: In mode 00 (functional), pad_out equals core_do and pad_oe equals core_oe.
- R7: In mode 01 (external test), each pin's pad_out and pad_oe come from its data and control latches. A control value of 1 enables the driver.
- R8: In mode 11 (high-Z), every pad_oe is 0 whatever the latches or the core drive.
- R9: In mode 10 (clamp), the pads come from the latches exactly as in mode 01 and do not follow the core inputs.
- R10: pad_weak_hi[k] is 1 exactly when pin k is marked open-drain in OPEN_DRAIN_MASK and pad_oe[k] is 0. It is never 1 for any other pin.
- R11: core_di always equals pad_in in every mode, because the observe cell has no update stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test logic reset, active low |
| tdi | input | 1 | Serial data into the top cell |
| capture_dr | input | 1 | Parallel capture strobe |
| shift_dr | input | 1 | Serial shift strobe |
| update_dr | input | 1 | Update strobe, sampled on the falling tck edge |
| mode | input | 2 | 00 functional, 01 external test, 10 clamp, 11 high-Z |
| core_do | input | NUM_PINS | Core output data |
| core_oe | input | NUM_PINS | Core output enable, 1 drives |
| core_di | output | NUM_PINS | Pad state returned to the core |
| pad_in | input | NUM_PINS | Pad level seen at the pins |
| pad_out | output | NUM_PINS | Data toward the pad drivers |
| pad_oe | output | NUM_PINS | Driver enable toward the pads |
| pad_weak_hi | output | NUM_PINS | Open-drain pin is released to its weak high |
| tdo | output | 1 | Serial data out of cell 0 |

## Verification
The bench builds the block with five pins, two placeholder cells per pin, a placeholder capture value of 1, and pins 1 and 2 marked open-drain. This gives a 25-cell chain. With this build, placeholder bits can be told apart from cleared cells, the filler branch of the generate is used, and both variants of the weak-high flag appear side by side. Random core and pad patterns are captured and shifted out against a computed chain image. Random shift-in images are then updated and examined in every mode. Directed cases cover simultaneous capture and shift, shifting while the pads are under test control, and a reset that arrives after all latches are set.

// File: rtl/bscan_pin_pkg.sv
package bscan_pin_pkg;

   typedef enum logic [1:0] {
      BSC_FUNC   = 2'b00,
      BSC_EXTEST = 2'b01,
      BSC_CLAMP  = 2'b10,
      BSC_HIGHZ  = 2'b11
   } bscan_mode_e;

   // cells per pin group and their offsets from the group base
   localparam int unsigned BSC_PIN_CELLS = 3;
   localparam int unsigned BSC_OFS_CTRL  = 0;
   localparam int unsigned BSC_OFS_DATA  = 1;
   localparam int unsigned BSC_OFS_OBS   = 2;

   // safe value for the update latches
   localparam logic BSC_SAFE = 1'b0;

endpackage

// File: rtl/bscan_pad_sel.sv
module bscan_pad_sel
   import bscan_pin_pkg::*;
(
   input  bscan_mode_e mode,
   input  logic        core_do,
   input  logic        core_oe,
   input  logic        upd_data,
   input  logic        upd_ctrl,
   output logic        pad_out,
   output logic        pad_oe
);

   always_comb begin
      unique case (mode)
         BSC_EXTEST, BSC_CLAMP: begin
            pad_out = upd_data;
            pad_oe  = upd_ctrl;
         end
         BSC_HIGHZ: begin
            pad_out = core_do;
            pad_oe  = 1'b0;
         end
         default: begin
            pad_out = core_do;
            pad_oe  = core_oe;
         end
      endcase
   end

endmodule

// File: rtl/bscan_filler_bank.sv
module bscan_filler_bank #(
   parameter int unsigned WIDTH     = 1,
   parameter bit          CAP_VALUE = 1'b0
) (
   input  logic             tck,
   input  logic             trst_n,
   input  logic             capture_dr,
   input  logic             shift_dr,
   input  logic             si,
   output logic [WIDTH-1:0] cell_q
);

   if (WIDTH < 1) begin : g_bad_width
      $error("bscan_filler_bank: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] shift_nxt;

   if (WIDTH == 1) begin : g_single
      assign shift_nxt = si;
   end else begin : g_multi
      assign shift_nxt = {si, cell_q[WIDTH-1:1]};
   end

   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         cell_q <= '0;
      end else if (capture_dr) begin
         cell_q <= {WIDTH{CAP_VALUE}};
      end else if (shift_dr) begin
         cell_q <= shift_nxt;
      end
   end

endmodule

// File: rtl/bscan_pin_group.sv
module bscan_pin_group
   import bscan_pin_pkg::*;
#(
   parameter bit OPEN_DRAIN = 1'b0
) (
   input  logic                     tck,
   input  logic                     trst_n,
   input  logic                     capture_dr,
   input  logic                     shift_dr,
   input  logic                     update_dr,
   input  bscan_mode_e              mode,
   input  logic                     si,
   input  logic                     core_do,
   input  logic                     core_oe,
   input  logic                     pad_in,
   output logic [BSC_PIN_CELLS-1:0] cell_q,
   output logic                     pad_out,
   output logic                     pad_oe,
   output logic                     pad_weak_hi
);

   logic obs_q;
   logic data_q;
   logic ctrl_q;
   logic data_upd;
   logic ctrl_upd;

   // shift stage: observe -> data -> control, toward the tdo end
   always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n) begin
         obs_q  <= 1'b0;
         data_q <= 1'b0;
         ctrl_q <= 1'b0;
      end else if (capture_dr) begin
         obs_q  <= pad_in;
         data_q <= core_do;
         ctrl_q <= core_oe;
      end else if (shift_dr) begin
         obs_q  <= si;
         data_q <= obs_q;
         ctrl_q <= data_q;
      end
   end

   // update stage, half a cycle after the last shift edge
   always_ff @(negedge tck or negedge trst_n) begin
      if (!trst_n) begin
         data_upd <= BSC_SAFE;
         ctrl_upd <= BSC_SAFE;
      end else if (update_dr) begin
         data_upd <= data_q;
         ctrl_upd <= ctrl_q;
      end
   end

   always_comb begin
      cell_q               = '0;
      cell_q[BSC_OFS_CTRL] = ctrl_q;
      cell_q[BSC_OFS_DATA] = data_q;
      cell_q[BSC_OFS_OBS]  = obs_q;
   end

   bscan_pad_sel u_sel (
      .mode     (mode),
      .core_do  (core_do),
      .core_oe  (core_oe),
      .upd_data (data_upd),
      .upd_ctrl (ctrl_upd),
      .pad_out  (pad_out),
      .pad_oe   (pad_oe)
   );

   if (OPEN_DRAIN) begin : g_od
      assign pad_weak_hi = ~pad_oe;
   end else begin : g_pp
      assign pad_weak_hi = 1'b0;
   end

endmodule

// File: rtl/bscan_pin_chain.sv
module bscan_pin_chain
   import bscan_pin_pkg::*;
#(
   parameter int unsigned          NUM_PINS        = 8,
   parameter int unsigned          FILL_CELLS      = 3,
   parameter bit                   FILL_VALUE      = 1'b0,
   parameter logic [NUM_PINS-1:0]  OPEN_DRAIN_MASK = {NUM_PINS{1'b0}}
) (
   input  logic                tck,
   input  logic                trst_n,
   input  logic                tdi,
   input  logic                capture_dr,
   input  logic                shift_dr,
   input  logic                update_dr,
   input  logic [1:0]          mode,
   input  logic [NUM_PINS-1:0] core_do,
   input  logic [NUM_PINS-1:0] core_oe,
   output logic [NUM_PINS-1:0] core_di,
   input  logic [NUM_PINS-1:0] pad_in,
   output logic [NUM_PINS-1:0] pad_out,
   output logic [NUM_PINS-1:0] pad_oe,
   output logic [NUM_PINS-1:0] pad_weak_hi,
   output logic                tdo
);

   localparam int unsigned SEG_CELLS = BSC_PIN_CELLS + FILL_CELLS;
   localparam int unsigned CHAIN_LEN = NUM_PINS * SEG_CELLS;

   if (NUM_PINS < 1) begin : g_bad_pins
      $error("bscan_pin_chain: NUM_PINS must be at least 1");
   end
   if (FILL_CELLS > 64) begin : g_bad_fill
      $error("bscan_pin_chain: FILL_CELLS above 64");
   end
   if (CHAIN_LEN > 4096) begin : g_bad_len
      $error("bscan_pin_chain: chain longer than 4096 cells");
   end

   bscan_mode_e       mode_e;
   logic [CHAIN_LEN-1:0] chain_q;

   assign mode_e  = bscan_mode_e'(mode);
   assign core_di = pad_in;
   assign tdo     = chain_q[0];

   for (genvar k = 0; k < NUM_PINS; k++) begin : g_seg
      localparam int unsigned BASE = k * SEG_CELLS;
      logic top_si;
      logic grp_si;

      if (k == NUM_PINS - 1) begin : g_head
         assign top_si = tdi;
      end else begin : g_link
         assign top_si = chain_q[BASE + SEG_CELLS];
      end

      if (FILL_CELLS > 0) begin : g_fill
         bscan_filler_bank #(
            .WIDTH     (FILL_CELLS),
            .CAP_VALUE (FILL_VALUE)
         ) u_fill (
            .tck        (tck),
            .trst_n     (trst_n),
            .capture_dr (capture_dr),
            .shift_dr   (shift_dr),
            .si         (top_si),
            .cell_q     (chain_q[BASE + SEG_CELLS - 1 : BASE + BSC_PIN_CELLS])
         );
         assign grp_si = chain_q[BASE + BSC_PIN_CELLS];
      end else begin : g_nofill
         assign grp_si = top_si;
      end

      bscan_pin_group #(
         .OPEN_DRAIN (OPEN_DRAIN_MASK[k])
      ) u_pin (
         .tck         (tck),
         .trst_n      (trst_n),
         .capture_dr  (capture_dr),
         .shift_dr    (shift_dr),
         .update_dr   (update_dr),
         .mode        (mode_e),
         .si          (grp_si),
         .core_do     (core_do[k]),
         .core_oe     (core_oe[k]),
         .pad_in      (pad_in[k]),
         .cell_q      (chain_q[BASE + BSC_PIN_CELLS - 1 : BASE]),
         .pad_out     (pad_out[k]),
         .pad_oe      (pad_oe[k]),
         .pad_weak_hi (pad_weak_hi[k])
      );
   end

endmodule

// File: rtl/bscan_pin_chain_chk.sv
module bscan_pin_chain_chk
   import bscan_pin_pkg::*;
#(
   parameter int unsigned         NUM_PINS        = 8,
   parameter logic [NUM_PINS-1:0] OPEN_DRAIN_MASK = {NUM_PINS{1'b0}}
) (
   input logic                tck,
   input logic                trst_n,
   input logic                capture_dr,
   input logic                update_dr,
   input logic [1:0]          mode,
   input logic [NUM_PINS-1:0] core_do,
   input logic [NUM_PINS-1:0] core_oe,
   input logic [NUM_PINS-1:0] core_di,
   input logic [NUM_PINS-1:0] pad_in,
   input logic [NUM_PINS-1:0] pad_out,
   input logic [NUM_PINS-1:0] pad_oe,
   input logic [NUM_PINS-1:0] pad_weak_hi,
   input logic                tdo
);

   p_reset_safe_r1: assert property (@(posedge tck) disable iff (!trst_n)
      $rose(trst_n) |-> (tdo == 1'b0) &&
         ((mode == BSC_FUNC) || (mode == BSC_HIGHZ) || (pad_oe == '0)));

   p_cell0_ctrl_r2: assert property (@(posedge tck) disable iff (!trst_n)
      capture_dr |=> tdo == $past(core_oe[0]));

   p_latch_hold_r5: assert property (@(negedge tck) disable iff (!trst_n)
      (mode == BSC_EXTEST && $past(mode) == BSC_EXTEST && !$past(update_dr))
      |-> $stable(pad_out) && $stable(pad_oe));

   p_func_follow_r6: assert property (@(posedge tck) disable iff (!trst_n)
      mode == BSC_FUNC |-> (pad_out == core_do) && (pad_oe == core_oe));

   p_highz_off_r8: assert property (@(posedge tck) disable iff (!trst_n)
      mode == BSC_HIGHZ |-> pad_oe == '0);

   p_weak_only_od_r10: assert property (@(posedge tck) disable iff (!trst_n)
      ((pad_weak_hi & ~OPEN_DRAIN_MASK) == '0) && ((pad_weak_hi & pad_oe) == '0));

   p_di_passthru_r11: assert property (@(posedge tck) disable iff (!trst_n)
      core_di == pad_in);

endmodule

bind bscan_pin_chain bscan_pin_chain_chk #(
   .NUM_PINS        (NUM_PINS),
   .OPEN_DRAIN_MASK (OPEN_DRAIN_MASK)
) u_chk (
   .tck         (tck),
   .trst_n      (trst_n),
   .capture_dr  (capture_dr),
   .update_dr   (update_dr),
   .mode        (mode),
   .core_do     (core_do),
   .core_oe     (core_oe),
   .core_di     (core_di),
   .pad_in      (pad_in),
   .pad_out     (pad_out),
   .pad_oe      (pad_oe),
   .pad_weak_hi (pad_weak_hi),
   .tdo         (tdo)
);

// File: tb/bscan_pin_chain_tb.sv
module bscan_pin_chain_tb;

   localparam int P   = 5;
   localparam int F   = 2;
   localparam int SEG = 3 + F;
   localparam int L   = P * SEG;
   localparam logic [P-1:0] OD = 5'b00110;
   localparam bit FV = 1'b1;

   logic tck = 1'b0;
   logic trst_n = 1'b0;
   logic tdi = 1'b0;
   logic capture_dr = 1'b0;
   logic shift_dr = 1'b0;
   logic update_dr = 1'b0;
   logic [1:0] mode = 2'b01;
   logic [P-1:0] core_do = '0;
   logic [P-1:0] core_oe = '0;
   logic [P-1:0] pad_in = '0;
   logic [P-1:0] core_di;
   logic [P-1:0] pad_out;
   logic [P-1:0] pad_oe;
   logic [P-1:0] pad_weak_hi;
   logic tdo;

   int checks = 0;
   int errors = 0;

   always #10 tck = ~tck;

   bscan_pin_chain #(
      .NUM_PINS (P), .FILL_CELLS (F), .FILL_VALUE (FV), .OPEN_DRAIN_MASK (OD)
   ) u_dut (
      .tck (tck), .trst_n (trst_n), .tdi (tdi), .capture_dr (capture_dr),
      .shift_dr (shift_dr), .update_dr (update_dr), .mode (mode),
      .core_do (core_do), .core_oe (core_oe), .core_di (core_di),
      .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe),
      .pad_weak_hi (pad_weak_hi), .tdo (tdo)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge tck);
      #2;
   endtask

   task automatic do_capture();
      capture_dr = 1'b1;
      step();
      capture_dr = 1'b0;
   endtask

   task automatic do_shift(input logic [L-1:0] vin, output logic [L-1:0] vout);
      shift_dr = 1'b1;
      for (int i = 0; i < L; i++) begin
         vout[i] = tdo;
         tdi = vin[i];
         step();
      end
      shift_dr = 1'b0;
   endtask

   task automatic do_update();
      update_dr = 1'b1;
      @(negedge tck);
      #2;
      update_dr = 1'b0;
   endtask

   function automatic logic [L-1:0] exp_capture(input logic [P-1:0] d, input logic [P-1:0] oe, input logic [P-1:0] pin);
      logic [L-1:0] v;
      for (int j = 0; j < L; j++) begin
         case (j % SEG)
            0: v[j] = oe[j / SEG];
            1: v[j] = d[j / SEG];
            2: v[j] = pin[j / SEG];
            default: v[j] = FV;
         endcase
      end
      return v;
   endfunction

   function automatic logic [P-1:0] lat_data(input logic [L-1:0] v);
      logic [P-1:0] r;
      for (int k = 0; k < P; k++) r[k] = v[k * SEG + 1];
      return r;
   endfunction

   function automatic logic [P-1:0] lat_ctrl(input logic [L-1:0] v);
      logic [P-1:0] r;
      for (int k = 0; k < P; k++) r[k] = v[k * SEG];
      return r;
   endfunction

   function automatic logic [L-1:0] rnd_chain();
      logic [31:0] t;
      t = $urandom;
      return t[L-1:0];
   endfunction

   function automatic logic [P-1:0] rnd_pins();
      logic [31:0] t;
      t = $urandom;
      return t[P-1:0];
   endfunction

   initial begin : watchdog
      #4000000;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : main
      logic [L-1:0] v_in, v_out, v_exp, w_in;
      logic [P-1:0] lo, lc;
      void'($urandom(32'h5EED_0B5C));

      // R1: state during reset in external test mode
      #5;
      check(tdo == 1'b0, "R1 tdo in reset", 64'(tdo), 64'd0);
      check(pad_oe == '0, "R1 oe in reset", 64'(pad_oe), 64'd0);
      check(pad_out == '0, "R1 data in reset", 64'(pad_out), 64'd0);
      check(pad_weak_hi == OD, "R10 weak in reset", 64'(pad_weak_hi), 64'(OD));
      step(); step();
      trst_n = 1'b1;
      step();

      for (int r = 0; r < 8; r++) begin
         mode = 2'b00;
         core_do = rnd_pins(); core_oe = rnd_pins(); pad_in = rnd_pins();
         if (r == 0) begin core_do = '1; core_oe = '0; pad_in = '1; end
         #1;
         check(pad_out == core_do && pad_oe == core_oe, "R6 functional pads",
               64'({pad_out, pad_oe}), 64'({core_do, core_oe}));
         check(core_di == pad_in, "R11 core_di", 64'(core_di), 64'(pad_in));
         check(pad_weak_hi == (OD & ~core_oe), "R10 weak functional",
               64'(pad_weak_hi), 64'(OD & ~core_oe));

         do_capture();
         v_exp = exp_capture(core_do, core_oe, pad_in);
         v_in = rnd_chain();
         if (r == 1) v_in = '1;
         do_shift(v_in, v_out);
         check(v_out == v_exp, "R2 R4 capture image", 64'(v_out), 64'(v_exp));

         do_update();
         mode = 2'b01;
         #1;
         lo = lat_data(v_in); lc = lat_ctrl(v_in);
         check(pad_out == lo && pad_oe == lc, "R7 extest pads",
               64'({pad_out, pad_oe}), 64'({lo, lc}));
         check(pad_weak_hi == (OD & ~lc), "R10 weak extest",
               64'(pad_weak_hi), 64'(OD & ~lc));

         w_in = rnd_chain();
         do_shift(w_in, v_out);
         check(v_out == v_in, "R5 R4 chain kept through update", 64'(v_out), 64'(v_in));
         check(pad_out == lo && pad_oe == lc, "R5 pads held while shifting",
               64'({pad_out, pad_oe}), 64'({lo, lc}));

         mode = 2'b10;
         core_do = ~core_do; core_oe = rnd_pins();
         #1;
         check(pad_out == lo && pad_oe == lc, "R9 clamp pads",
               64'({pad_out, pad_oe}), 64'({lo, lc}));

         mode = 2'b11;
         #1;
         check(pad_oe == '0, "R8 highz oe", 64'(pad_oe), 64'd0);
         check(pad_weak_hi == OD, "R10 weak highz", 64'(pad_weak_hi), 64'(OD));
         check(core_di == pad_in, "R11 core_di highz", 64'(core_di), 64'(pad_in));
         step();
      end

      // R3: capture wins over shift
      mode = 2'b00;
      core_do = 5'b10110; core_oe = 5'b01101; pad_in = 5'b11001;
      tdi = 1'b0;
      capture_dr = 1'b1; shift_dr = 1'b1;
      step();
      capture_dr = 1'b0; shift_dr = 1'b0;
      v_exp = exp_capture(core_do, core_oe, pad_in);
      do_shift('0, v_out);
      check(v_out == v_exp, "R3 capture priority", 64'(v_out), 64'(v_exp));

      // R4: first tdi bit reaches tdo after exactly L shifts
      do_shift({{(L-1){1'b0}}, 1'b1}, v_out);
      check(tdo == 1'b1, "R4 latency", 64'(tdo), 64'd1);

      // R1: asynchronous reset after all latches are set
      do_shift('1, v_out);
      do_update();
      mode = 2'b01;
      #1;
      check(pad_oe == '1, "R7 all enabled", 64'(pad_oe), 64'h1f);
      trst_n = 1'b0;
      #3;
      check(pad_oe == '0 && pad_out == '0, "R1 async reset to safe",
            64'({pad_out, pad_oe}), 64'd0);
      check(tdo == 1'b0, "R1 tdo after reset", 64'(tdo), 64'd0);
      step(); step();
      trst_n = 1'b1;
      step();
      check(pad_oe == '0, "R1 safe after release", 64'(pad_oe), 64'd0);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule